// File: doc/BRIEF.md
# Capability Load Revocation Filter

This block sits on the return path of capability loads, between the memory response and the register file. When a load returns a capability that still carries its tag, the filter takes the capability's decoded base address and finds the matching bit in a freed-granule bitmap held in memory. Each 8-byte granule of the revocable heap has one bit in that bitmap. If the bit is set, the capability is passed on with its tag cleared. A capability that points to freed memory therefore never reaches a register as a valid capability.

Three kinds of response skip the bitmap: untagged responses, plain data loads, and capabilities whose base lies outside the heap window. They pass through in the same cycle, with no register on the path. A response that needs the lookup is accepted at once. It is then held inside the block while a single 32-bit bitmap word is read over a read port with a fixed latency. The result is offered on a valid/ready handshake and stays until the consumer takes it. The heap window, the bitmap base address, the granule size and the read latency are all parameters.

Top module: `cap_revoke_filter`

## Requirements
- R1: After reset, with no load presented, `rf_valid_o` and `bm_req_o` are low.
- R2: A response with `ld_tag_i` low, or with `ld_is_cap_i` low, appears on the `rf_*` outputs unchanged in the same cycle, `ld_ready_o` follows `rf_ready_i`, and no bitmap read is issued.
- R3: A tagged capability whose base lies in the heap window is accepted in the cycle it is presented (`ld_ready_o` high) and raises `bm_req_o` in that cycle. The request address is `BITMAP_BASE + 4*floor(idx/32)`, where `idx = (base - HEAP_START)/8`.
- R4: If the bitmap bit for the base granule is 1 (freed), the response is delivered with `rf_tag_o` = 0, with `rf_data_o` and `rf_is_cap_o` as loaded.
- R5: If that bitmap bit is 0, the response is delivered with `rf_tag_o` = 1 and its data unchanged.
- R6: The bit that decides is bit `idx mod 32` of the returned 32-bit word, where bit 0 is the least significant bit.
- R7: A tagged capability whose base is below `HEAP_START`, or at or above `HEAP_START + HEAP_SIZE`, passes through unchanged in the same cycle with its tag kept, and no bitmap read is issued.
- R8: A looked-up response raises `rf_valid_o` exactly `RD_LAT + 1` cycles after the cycle in which it was accepted. In the cycles between, `rf_valid_o` and `ld_ready_o` stay low.
- R9: A held response keeps `rf_valid_o`, `rf_data_o` and `rf_tag_o` steady until `rf_ready_i` is high. While it waits, `ld_ready_o` is low and a newly presented load is neither passed through nor accepted.
- R10: Only `ld_base_i` decides the lookup. An address held in the capability data that falls in a freed granule has no effect.
- R11: A zero-length capability whose base is the first byte after an allocation is judged by the bit of that granule, the same as any other base.
- R12: The filter never raises a tag. A response loaded untagged always leaves with `rf_tag_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ld_valid_i | input | 1 | Load response valid |
| ld_ready_o | output | 1 | Load response accepted |
| ld_is_cap_i | input | 1 | Response is a capability load |
| ld_tag_i | input | 1 | Tag bit returned from memory |
| ld_data_i | input | DATA_W | Loaded capability or data word |
| ld_base_i | input | ADDR_W | Decoded base address of the loaded capability |
| bm_req_o | output | 1 | Bitmap word read request |
| bm_addr_o | output | ADDR_W | Byte address of the bitmap word |
| bm_rdata_i | input | 32 | Bitmap word, valid RD_LAT cycles after the request |
| rf_valid_o | output | 1 | Filtered response valid |
| rf_ready_i | input | 1 | Register file accepts the response |
| rf_is_cap_o | output | 1 | Filtered response is a capability |
| rf_tag_o | output | 1 | Filtered tag |
| rf_data_o | output | DATA_W | Filtered data |

## Verification
Two functions can meet in one cycle: a held, looked-up response waiting for the consumer, and a new response arriving that would take the same-cycle bypass. The bench provokes this by stalling `rf_ready_i` after a lookup while it presents an untagged load on the input. It then checks that the outputs still carry the held capability and that `ld_ready_o` stays low. Once the consumer accepts, it checks that the waiting load comes through in the next cycle. The checker also ties every bitmap request to a busy port in the next cycle.

// File: rtl/crf_pkg.sv
package crf_pkg;

   localparam int unsigned BM_WORD_BITS = 32;
   localparam int unsigned BM_BIT_W     = $clog2(BM_WORD_BITS);
   localparam int unsigned BM_WORD_SHL  = $clog2(BM_WORD_BITS / 8);

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_HOLD = 2'd2
   } state_e;

endpackage

// File: rtl/crf_locate.sv
// Maps a capability base onto the heap window and the bitmap word/bit.
module crf_locate #(
   parameter int unsigned       ADDR_W      = 32,
   parameter int unsigned       GRAN_BYTES  = 8,
   parameter logic [ADDR_W-1:0] HEAP_START  = '0,
   parameter logic [ADDR_W-1:0] HEAP_SIZE   = '0,
   parameter logic [ADDR_W-1:0] BITMAP_BASE = '0
) (
   input  logic [ADDR_W-1:0]            base_i,
   output logic                         in_heap_o,
   output logic [ADDR_W-1:0]            word_addr_o,
   output logic [crf_pkg::BM_BIT_W-1:0] bit_o
);
   import crf_pkg::*;

   localparam int unsigned GRAN_SHIFT = $clog2(GRAN_BYTES);

   logic [ADDR_W-1:0] offset;
   logic [ADDR_W-1:0] gran_idx;
   logic [ADDR_W-1:0] word_idx;

   always_comb begin
      offset      = base_i - HEAP_START;
      in_heap_o   = (base_i >= HEAP_START) && (offset < HEAP_SIZE);
      gran_idx    = offset >> GRAN_SHIFT;
      word_idx    = gran_idx >> BM_BIT_W;
      word_addr_o = BITMAP_BASE + (word_idx << BM_WORD_SHL);
      bit_o       = gran_idx[BM_BIT_W-1:0];
   end

endmodule

// File: rtl/crf_seq.sv
// Sequencer: waits the bitmap latency, samples the revocation bit, holds result.
module crf_seq #(
   parameter int unsigned RD_LAT = 2
) (
   input  logic                                clk_i,
   input  logic                                rst_ni,
   input  logic                                start_i,
   input  logic [crf_pkg::BM_BIT_W-1:0]        bit_i,
   input  logic [crf_pkg::BM_WORD_BITS-1:0]    rdata_i,
   input  logic                                taken_i,
   output crf_pkg::state_e                     state_o,
   output logic                                freed_o
);
   import crf_pkg::*;

   state_e              state_q;
   logic [BM_BIT_W-1:0] bit_q;
   logic                freed_q;
   logic                last_wait;

   generate
      if (RD_LAT == 1) begin : g_lat_one
         assign last_wait = 1'b1;
      end else begin : g_lat_cnt
         localparam int unsigned CNT_W = $clog2(RD_LAT + 1);
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               cnt_q <= '0;
            end else if (start_i) begin
               cnt_q <= CNT_W'(RD_LAT);
            end else if (state_q == ST_WAIT) begin
               cnt_q <= cnt_q - 1'b1;
            end
         end
         assign last_wait = (cnt_q == CNT_W'(1));
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         bit_q   <= '0;
         freed_q <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (start_i) begin
               state_q <= ST_WAIT;
               bit_q   <= bit_i;
            end
            ST_WAIT: if (last_wait) begin
               state_q <= ST_HOLD;
               freed_q <= rdata_i[bit_q];
            end
            ST_HOLD: if (taken_i) state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign state_o = state_q;
   assign freed_o = freed_q;

endmodule

// File: rtl/crf_hold.sv
// Storage for the response payload while the bitmap is consulted.
module crf_hold #(
   parameter int unsigned DATA_W = 64
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              load_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [DATA_W-1:0] data_o
);
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     data_o <= '0;
      else if (load_i) data_o <= data_i;
   end
endmodule

// File: rtl/cap_revoke_filter.sv
module cap_revoke_filter #(
   parameter int unsigned       ADDR_W      = 32,
   parameter int unsigned       DATA_W      = 64,
   parameter int unsigned       GRAN_BYTES  = 8,
   parameter int unsigned       RD_LAT      = 2,
   parameter logic [ADDR_W-1:0] HEAP_START  = 32'h2000_0000,
   parameter logic [ADDR_W-1:0] HEAP_SIZE   = 32'h0001_0000,
   parameter logic [ADDR_W-1:0] BITMAP_BASE = 32'h3000_0000
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              ld_valid_i,
   output logic              ld_ready_o,
   input  logic              ld_is_cap_i,
   input  logic              ld_tag_i,
   input  logic [DATA_W-1:0] ld_data_i,
   input  logic [ADDR_W-1:0] ld_base_i,
   output logic              bm_req_o,
   output logic [ADDR_W-1:0] bm_addr_o,
   input  logic [31:0]       bm_rdata_i,
   output logic              rf_valid_o,
   input  logic              rf_ready_i,
   output logic              rf_is_cap_o,
   output logic              rf_tag_o,
   output logic [DATA_W-1:0] rf_data_o
);
   import crf_pkg::*;

   // elaboration-time parameter checks
   if (RD_LAT < 1) begin : g_bad_lat
      $error("RD_LAT must be at least 1");
   end
   if ((GRAN_BYTES < 2) || ((GRAN_BYTES & (GRAN_BYTES - 1)) != 0)) begin : g_bad_gran
      $error("GRAN_BYTES must be a power of two");
   end
   if ((HEAP_START % GRAN_BYTES) != 0 || (HEAP_SIZE % GRAN_BYTES) != 0) begin : g_bad_heap
      $error("heap window must be granule aligned");
   end
   if ((BITMAP_BASE % 4) != 0) begin : g_bad_bm
      $error("BITMAP_BASE must be word aligned");
   end

   logic                in_heap;
   logic [ADDR_W-1:0]   word_addr;
   logic [BM_BIT_W-1:0] bit_sel;
   logic                needs_lookup;
   logic                idle;
   logic                bypass;
   logic                start;
   logic                freed;
   logic [DATA_W-1:0]   data_q;
   state_e              state;

   crf_locate #(
      .ADDR_W      (ADDR_W),
      .GRAN_BYTES  (GRAN_BYTES),
      .HEAP_START  (HEAP_START),
      .HEAP_SIZE   (HEAP_SIZE),
      .BITMAP_BASE (BITMAP_BASE)
   ) i_locate (
      .base_i      (ld_base_i),
      .in_heap_o   (in_heap),
      .word_addr_o (word_addr),
      .bit_o       (bit_sel)
   );

   assign needs_lookup = ld_is_cap_i & ld_tag_i & in_heap;
   assign idle         = (state == ST_IDLE);
   assign bypass       = idle & ~needs_lookup;
   assign start        = idle & ld_valid_i & needs_lookup;

   crf_seq #(
      .RD_LAT (RD_LAT)
   ) i_seq (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (start),
      .bit_i   (bit_sel),
      .rdata_i (bm_rdata_i),
      .taken_i (rf_ready_i),
      .state_o (state),
      .freed_o (freed)
   );

   crf_hold #(
      .DATA_W (DATA_W)
   ) i_hold (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (start),
      .data_i (ld_data_i),
      .data_o (data_q)
   );

   assign bm_req_o    = start;
   assign bm_addr_o   = word_addr;
   assign ld_ready_o  = idle & (needs_lookup | rf_ready_i);
   assign rf_valid_o  = bypass ? ld_valid_i  : (state == ST_HOLD);
   assign rf_is_cap_o = bypass ? ld_is_cap_i : 1'b1;
   assign rf_tag_o    = bypass ? ld_tag_i    : ~freed;
   assign rf_data_o   = bypass ? ld_data_i   : data_q;

endmodule

// File: rtl/crf_chk.sv
module crf_chk #(
   parameter int unsigned       ADDR_W      = 32,
   parameter int unsigned       DATA_W      = 64,
   parameter logic [ADDR_W-1:0] BITMAP_BASE = '0
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              ld_valid_i,
   input logic              ld_ready_o,
   input logic              ld_is_cap_i,
   input logic              ld_tag_i,
   input logic [DATA_W-1:0] ld_data_i,
   input logic              bm_req_o,
   input logic [ADDR_W-1:0] bm_addr_o,
   input logic              rf_valid_o,
   input logic              rf_ready_i,
   input logic              rf_tag_o,
   input logic [DATA_W-1:0] rf_data_o,
   input crf_pkg::state_e   state
);
   import crf_pkg::*;

   // R2
   untagged_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state == ST_IDLE && ld_valid_i && !(ld_is_cap_i && ld_tag_i))
         |-> (rf_valid_o && rf_data_o == ld_data_i && !bm_req_o));

   // R3
   req_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bm_req_o |-> (ld_ready_o && ld_valid_i && bm_addr_o[1:0] == BITMAP_BASE[1:0]));

   // R8
   req_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bm_req_o |=> (!rf_valid_o && !ld_ready_o));

   // R9
   hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state == ST_HOLD && !rf_ready_i)
         |=> (rf_valid_o && $stable(rf_data_o) && $stable(rf_tag_o) && !ld_ready_o));

   // R12
   no_tag_raise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state == ST_IDLE && rf_valid_o && rf_tag_o) |-> ld_tag_i);

endmodule

bind cap_revoke_filter crf_chk #(
   .ADDR_W      (ADDR_W),
   .DATA_W      (DATA_W),
   .BITMAP_BASE (BITMAP_BASE)
) i_crf_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .ld_valid_i  (ld_valid_i),
   .ld_ready_o  (ld_ready_o),
   .ld_is_cap_i (ld_is_cap_i),
   .ld_tag_i    (ld_tag_i),
   .ld_data_i   (ld_data_i),
   .bm_req_o    (bm_req_o),
   .bm_addr_o   (bm_addr_o),
   .rf_valid_o  (rf_valid_o),
   .rf_ready_i  (rf_ready_i),
   .rf_tag_o    (rf_tag_o),
   .rf_data_o   (rf_data_o),
   .state       (state)
);

// File: tb/test_cap_revoke_filter.sv
module test_cap_revoke_filter;
   localparam int unsigned RD_LAT = 2;
   localparam logic [31:0] HS     = 32'h2000_0000;
   localparam logic [31:0] HSIZE  = 32'h0001_0000;
   localparam logic [31:0] BB     = 32'h3000_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ld_valid = 1'b0, ld_ready, ld_is_cap = 1'b0, ld_tag = 1'b0;
   logic [63:0] ld_data = '0;
   logic [31:0] ld_base = '0;
   logic        bm_req;
   logic [31:0] bm_addr, bm_rdata;
   logic        rf_valid, rf_ready = 1'b1, rf_is_cap, rf_tag;
   logic [63:0] rf_data;

   int checks = 0, errors = 0;
   logic [31:0] bm_mem [0:255];
   logic [31:0] pipe [1:RD_LAT];

   always #4 clk = ~clk;

   cap_revoke_filter #(
      .RD_LAT (RD_LAT), .HEAP_START (HS), .HEAP_SIZE (HSIZE), .BITMAP_BASE (BB)
   ) i_cap_revoke_filter (
      .clk_i (clk), .rst_ni (rst_n),
      .ld_valid_i (ld_valid), .ld_ready_o (ld_ready), .ld_is_cap_i (ld_is_cap),
      .ld_tag_i (ld_tag), .ld_data_i (ld_data), .ld_base_i (ld_base),
      .bm_req_o (bm_req), .bm_addr_o (bm_addr), .bm_rdata_i (bm_rdata),
      .rf_valid_o (rf_valid), .rf_ready_i (rf_ready), .rf_is_cap_o (rf_is_cap),
      .rf_tag_o (rf_tag), .rf_data_o (rf_data)
   );

   // bitmap memory model with fixed read latency
   always_ff @(posedge clk) begin
      pipe[1] <= bm_req ? bm_addr : 32'h0;
      for (int k = 2; k <= RD_LAT; k++) pipe[k] <= pipe[k-1];
   end
   assign bm_rdata = bm_mem[8'((pipe[RD_LAT] - BB) >> 2)];

   function automatic int gidx(input logic [31:0] base);
      return int'((base - HS) >> 3);
   endfunction

   task automatic chk(input logic ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   task automatic set_freed(input logic [31:0] base, input logic v);
      int i = gidx(base);
      bm_mem[i / 32][i % 32] = v;
   endtask

   // one load; lookup path checks request address, latency, tag and data
   task automatic run_load(input string rq, input logic cap, input logic tg,
                           input logic [63:0] dat, input logic [31:0] base,
                           input logic lookup, input logic exp_tag, input int stall);
      logic [31:0] exp_addr;
      exp_addr = BB + 32'((gidx(base) / 32) * 4);
      @(negedge clk);
      ld_valid = 1'b1; ld_is_cap = cap; ld_tag = tg; ld_data = dat; ld_base = base;
      rf_ready = 1'b1;
      #1;
      if (!lookup) begin
         chk(rf_valid == 1'b1, {rq, " same-cycle valid"}, 64'(rf_valid), 64'd1);
         chk(rf_data == dat, {rq, " data"}, rf_data, dat);
         chk(rf_tag == exp_tag, {rq, " tag"}, 64'(rf_tag), 64'(exp_tag));
         chk(bm_req == 1'b0, {rq, " no bitmap read"}, 64'(bm_req), 64'd0);
         chk(ld_ready == 1'b1, {rq, " ready follows consumer"}, 64'(ld_ready), 64'd1);
         @(negedge clk);
         ld_valid = 1'b0;
      end else begin
         chk(bm_req && ld_ready, {rq, " R3 accept+req"}, 64'({bm_req, ld_ready}), 64'd3);
         chk(bm_addr == exp_addr, {rq, " R3 bitmap addr"}, 64'(bm_addr), 64'(exp_addr));
         chk(rf_valid == 1'b0, {rq, " R8 not yet valid"}, 64'(rf_valid), 64'd0);
         @(negedge clk);
         ld_valid = 1'b0;
         rf_ready = (stall == 0);
         for (int c = 1; c <= RD_LAT; c++) begin
            chk(!rf_valid && !ld_ready, {rq, " R8 waiting"}, 64'({rf_valid, ld_ready}), 64'd0);
            @(negedge clk);
         end
         chk(rf_valid == 1'b1, {rq, " R8 valid at RD_LAT+1"}, 64'(rf_valid), 64'd1);
         chk(rf_tag == exp_tag, {rq, " tag"}, 64'(rf_tag), 64'(exp_tag));
         chk(rf_data == dat && rf_is_cap, {rq, " data kept"}, rf_data, dat);
         for (int s = 0; s < stall; s++) begin
            @(negedge clk);
            chk(rf_valid && rf_data == dat && rf_tag == exp_tag && !ld_ready,
                {rq, " R9 hold"}, rf_data, dat);
         end
         rf_ready = 1'b1;
         @(negedge clk);
         chk(rf_valid == 1'b0, {rq, " released"}, 64'(rf_valid), 64'd0);
      end
   endtask

   task automatic t_reset;
      chk(!rf_valid && !bm_req, "R1 reset outputs", 64'({rf_valid, bm_req}), 64'd0);
   endtask

   task automatic t_bypass;
      set_freed(HS + 32'h40, 1'b1);
      run_load("R2 untagged cap", 1'b1, 1'b0, 64'h1111, HS + 32'h40, 1'b0, 1'b0, 0);
      run_load("R2 plain data load", 1'b0, 1'b1, 64'h2222, HS + 32'h40, 1'b0, 1'b1, 0);
      run_load("R12 untagged stays untagged", 1'b1, 1'b0, 64'h2323, HS + 32'h48, 1'b0, 1'b0, 0);
      @(negedge clk);
      ld_valid = 1'b1; ld_is_cap = 1'b0; ld_tag = 1'b0; rf_ready = 1'b0;
      #1;
      chk(ld_ready == 1'b0, "R2 ready follows stalled consumer", 64'(ld_ready), 64'd0);
      @(negedge clk);
      ld_valid = 1'b0; rf_ready = 1'b1;
   endtask

   task automatic t_outside;
      run_load("R7 below heap", 1'b1, 1'b1, 64'h3333, HS - 32'h8, 1'b0, 1'b1, 0);
      run_load("R7 at heap end", 1'b1, 1'b1, 64'h4444, HS + HSIZE, 1'b0, 1'b1, 0);
   endtask

   task automatic t_live_freed;
      run_load("R5 live granule", 1'b1, 1'b1, 64'h5555, HS + 32'h88, 1'b1, 1'b1, 0);
      set_freed(HS + 32'h90, 1'b1);
      run_load("R4 freed granule", 1'b1, 1'b1, 64'h6666, HS + 32'h94, 1'b1, 1'b0, 0);
   endtask

   task automatic t_bitpos;
      set_freed(HS + 32'd31 * 8, 1'b1);
      run_load("R6 idx31 freed", 1'b1, 1'b1, 64'h7777, HS + 32'd31 * 8, 1'b1, 1'b0, 0);
      run_load("R6 idx30 live", 1'b1, 1'b1, 64'h7778, HS + 32'd30 * 8, 1'b1, 1'b1, 0);
      run_load("R6 idx32 next word", 1'b1, 1'b1, 64'h7779, HS + 32'd32 * 8, 1'b1, 1'b1, 0);
      set_freed(HS + HSIZE - 32'h8, 1'b1);
      run_load("R6 last granule", 1'b1, 1'b1, 64'h777a, HS + HSIZE - 32'h8, 1'b1, 1'b0, 0);
   endtask

   task automatic t_base_only;
      set_freed(HS + 32'h400, 1'b1);
      run_load("R10 data addr freed, base live", 1'b1, 1'b1, {32'h0, HS + 32'h400},
               HS + 32'h800, 1'b1, 1'b1, 0);
      run_load("R10 base freed, data addr live", 1'b1, 1'b1, {32'h0, HS + 32'h800},
               HS + 32'h404, 1'b1, 1'b0, 0);
   endtask

   task automatic t_zero_len;
      for (int g = 100; g < 104; g++) set_freed(HS + 32'(g * 8), 1'b1);
      run_load("R11 one-past-end live next", 1'b1, 1'b1, 64'h0, HS + 32'd104 * 8, 1'b1, 1'b1, 0);
      set_freed(HS + 32'd104 * 8, 1'b1);
      run_load("R11 one-past-end freed next", 1'b1, 1'b1, 64'h0, HS + 32'd104 * 8, 1'b1, 1'b0, 0);
   endtask

   // a held result meets a newly arriving bypass load
   task automatic t_overlap;
      run_load("R9 stalled consumer", 1'b1, 1'b1, 64'hAAAA, HS + 32'h88, 1'b1, 1'b1, 3);
      @(negedge clk);
      ld_valid = 1'b1; ld_is_cap = 1'b1; ld_tag = 1'b1; ld_data = 64'hBEEF;
      ld_base = HS + 32'h88; rf_ready = 1'b0;
      @(negedge clk);
      ld_valid = 1'b0;
      repeat (RD_LAT) @(negedge clk);
      ld_valid = 1'b1; ld_is_cap = 1'b0; ld_tag = 1'b0; ld_data = 64'hC0DE;
      #1;
      chk(rf_valid && rf_data == 64'hBEEF && rf_tag, "R9 held beats new load", rf_data, 64'hBEEF);
      chk(ld_ready == 1'b0, "R9 new load refused", 64'(ld_ready), 64'd0);
      rf_ready = 1'b1;
      @(negedge clk);
      chk(rf_valid && rf_data == 64'hC0DE, "R9 waiting load follows", rf_data, 64'hC0DE);
      @(negedge clk);
      ld_valid = 1'b0;
   endtask

   initial begin
      for (int w = 0; w < 256; w++) bm_mem[w] = '0;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_bypass();
      t_outside();
      t_live_freed();
      t_bitpos();
      t_base_only();
      t_zero_len();
      t_overlap();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #200000;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule